// File: doc/BRIEF.md
# Virtual-Channel Frame Integrity Checker

This block watches the decoded packet stream of a camera serial receiver and keeps a separate frame state for each of four virtual channels. It takes two kinds of event: a short-packet event carrying a data type and a channel number, and a long-packet completion event carrying a channel number and a flag that says the payload CRC check failed. From these it finds frame ends that arrive without an opening frame start, and frames whose payload carried a CRC error. It also marks every received frame end.

All results come out as single-cycle pulses on a 32-bit word. Each bit sits at the position the interrupt status register expects, so the word can be OR-ed straight into that register's sticky bits. A CRC error is not reported when it occurs. It is remembered per channel and reported only when that channel's frame closes. A flush input, driven by the core's soft reset or disable, returns every channel to idle.

Top module: `vc_frame_checker`

## Requirements
- R1: After reset every output bit is 0 and every channel is idle, so a frame end as the first event on any channel counts as unpaired.
- R2: A frame end on channel n while channel n is idle sets status bit 2n+1 (synchronisation error) for exactly one cycle, in the cycle after the event.
- R3: If channel n saw a long packet with a CRC error after its frame start, the closing frame end on n sets status bit 2n (frame data error) for one cycle, in the cycle after the frame end.
- R4: A frame end that closes an open frame with no CRC error sets no error bit.
- R5: Every accepted frame end, paired or not, on any channel sets status bit 31 for one cycle, in the cycle after the event.
- R6: Bits 30 to 8 are always 0, and at most one channel error bit is set in any cycle.
- R7: The short-packet data type 0x00 is frame start and 0x01 is frame end. Any other data type leaves all frame state unchanged and produces no pulse.
- R8: A frame start on a channel that is already open restarts that frame and drops any CRC error held for it.
- R9: While flush is high, all channels return to idle, events in that cycle are ignored, and no pulse is produced in the following cycle.
- R10: Events for different channels on consecutive cycles, or a long packet on one channel in the same cycle as a short packet on another, act only on their own channel.
- R11: A CRC error on an idle channel is ignored. A CRC error in the same cycle as a frame start on that channel belongs to the new frame. A CRC error in the same cycle as a frame end on that channel belongs to the closing frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Soft reset or disable: forces all channels idle |
| sp_valid | input | 1 | Short-packet event present |
| sp_dtype | input | 6 | Data type of the short packet |
| sp_vc | input | 2 | Virtual channel of the short packet |
| lp_done | input | 1 | Long-packet completion event present |
| lp_vc | input | 2 | Virtual channel of the long packet |
| lp_crc_err | input | 1 | Payload CRC failed for that long packet |
| status_pulse | output | 32 | Single-cycle event word aligned to interrupt status bits |

## Verification
Every result is registered once. A pulse caused by the events on the inputs at one rising edge appears on `status_pulse` right after that edge, and it stays there for exactly that one cycle. The driver applies one set of events per cycle on the falling edge. It then queues the word a requirement-based model predicts for that cycle. The monitor compares one queued word with the output 2 ns after each rising edge, so each event is checked in the cycle its pulse is due and absence of pulses is checked in every other cycle.

// File: rtl/vcfc_pkg.sv
package vcfc_pkg;

    localparam int STAT_W         = 32;
    localparam int FRAME_RCVD_BIT = 31;
    localparam int DT_W           = 6;

    localparam logic [DT_W-1:0] DT_FRAME_START = 6'h00;
    localparam logic [DT_W-1:0] DT_FRAME_END   = 6'h01;

    // per-channel decoded events for one cycle
    typedef struct packed {
        logic fs;
        logic fe;
        logic crc;
    } chan_hit_t;

    // per-channel registered results
    typedef struct packed {
        logic sync_err;
        logic data_err;
    } chan_flag_t;

    function automatic int sync_bit_pos(input int ch);
        return 2 * ch + 1;
    endfunction

    function automatic int data_bit_pos(input int ch);
        return 2 * ch;
    endfunction

endpackage

// File: rtl/vcfc_event_decode.sv
module vcfc_event_decode
    import vcfc_pkg::*;
#(
    parameter int NUM_VC = 4,
    localparam int VC_W = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
    input  logic            sp_valid,
    input  logic [DT_W-1:0] sp_dtype,
    input  logic [VC_W-1:0] sp_vc,
    input  logic            lp_done,
    input  logic [VC_W-1:0] lp_vc,
    input  logic            lp_crc_err,
    output chan_hit_t       hits [NUM_VC],
    output logic            any_fe
);

    logic is_fs;
    logic is_fe;

    always_comb begin
        is_fs  = sp_valid && (sp_dtype == DT_FRAME_START);
        is_fe  = sp_valid && (sp_dtype == DT_FRAME_END);
        any_fe = is_fe;
    end

    for (genvar c = 0; c < NUM_VC; c++) begin : g_hit
        always_comb begin
            hits[c].fs  = is_fs && (sp_vc == VC_W'(c));
            hits[c].fe  = is_fe && (sp_vc == VC_W'(c));
            hits[c].crc = lp_done && lp_crc_err && (lp_vc == VC_W'(c));
        end
    end

endmodule

// File: rtl/vcfc_chan_state.sv
module vcfc_chan_state
    import vcfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  chan_hit_t  hit,
    output chan_flag_t flag
);

    logic in_frame;
    logic crc_pend;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            in_frame <= 1'b0;
            crc_pend <= 1'b0;
            flag     <= '0;
        end else begin
            flag.sync_err <= hit.fe && !in_frame;
            flag.data_err <= hit.fe && in_frame && (crc_pend || hit.crc);
            if (hit.fs) begin
                in_frame <= 1'b1;
                crc_pend <= hit.crc;
            end else if (hit.fe) begin
                in_frame <= 1'b0;
                crc_pend <= 1'b0;
            end else if (hit.crc && in_frame) begin
                crc_pend <= 1'b1;
            end
        end
    end

    // R8
    restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (hit.fs && !hit.crc && !flush) |=> (in_frame && !crc_pend));

    // R9
    flush_idle_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!in_frame && !crc_pend && flag == '0));

    // R2
    sync_cause_chk: assert property (@(posedge clk) disable iff (rst)
        flag.sync_err |-> $past(hit.fe && !flush));

    // R11
    idle_crc_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_frame && !hit.fs) |=> !crc_pend);

    // R2
    error_kinds_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(flag.sync_err && flag.data_err));

endmodule

// File: rtl/vcfc_status_map.sv
module vcfc_status_map
    import vcfc_pkg::*;
#(
    parameter int NUM_VC = 4
) (
    input  chan_flag_t        flags [NUM_VC],
    input  logic              frame_rcvd,
    output logic [STAT_W-1:0] status
);

    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        if (b == FRAME_RCVD_BIT) begin : g_rcvd
            assign status[b] = frame_rcvd;
        end else if (b < 2 * NUM_VC && (b % 2) == 1) begin : g_sync
            assign status[b] = flags[b / 2].sync_err;
        end else if (b < 2 * NUM_VC) begin : g_data
            assign status[b] = flags[b / 2].data_err;
        end else begin : g_zero
            assign status[b] = 1'b0;
        end
    end

endmodule

// File: rtl/vc_frame_checker.sv
module vc_frame_checker
    import vcfc_pkg::*;
#(
    parameter int NUM_VC = 4,
    localparam int VC_W = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              sp_valid,
    input  logic [DT_W-1:0]   sp_dtype,
    input  logic [VC_W-1:0]   sp_vc,
    input  logic              lp_done,
    input  logic [VC_W-1:0]   lp_vc,
    input  logic              lp_crc_err,
    output logic [STAT_W-1:0] status_pulse
);

    chan_hit_t  hits  [NUM_VC];
    chan_flag_t flags [NUM_VC];
    logic       any_fe;
    logic       rcvd_q;

    vcfc_event_decode #(.NUM_VC(NUM_VC)) i_decode (
        .sp_valid   (sp_valid),
        .sp_dtype   (sp_dtype),
        .sp_vc      (sp_vc),
        .lp_done    (lp_done),
        .lp_vc      (lp_vc),
        .lp_crc_err (lp_crc_err),
        .hits       (hits),
        .any_fe     (any_fe)
    );

    for (genvar c = 0; c < NUM_VC; c++) begin : g_chan
        vcfc_chan_state i_chan (
            .clk   (clk),
            .rst   (rst),
            .flush (flush),
            .hit   (hits[c]),
            .flag  (flags[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || flush) rcvd_q <= 1'b0;
        else              rcvd_q <= any_fe;
    end

    vcfc_status_map #(.NUM_VC(NUM_VC)) i_map (
        .flags      (flags),
        .frame_rcvd (rcvd_q),
        .status     (status_pulse)
    );

    // R5
    rcvd_cause_chk: assert property (@(posedge clk) disable iff (rst)
        status_pulse[FRAME_RCVD_BIT] |->
            $past(sp_valid && sp_dtype == DT_FRAME_END && !flush));

    // R6
    one_err_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(status_pulse[2*NUM_VC-1:0]));

    // R5
    err_has_rcvd_chk: assert property (@(posedge clk) disable iff (rst)
        (|status_pulse[2*NUM_VC-1:0]) |-> status_pulse[FRAME_RCVD_BIT]);

    // R9
    flush_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (status_pulse == '0));

endmodule

// File: tb/test_vc_frame_checker.sv
module test_vc_frame_checker;
    import vcfc_pkg::*;

    logic        clk = 1'b0;
    logic        rst, flush, sp_valid, lp_done, lp_crc_err;
    logic [5:0]  sp_dtype;
    logic [1:0]  sp_vc, lp_vc;
    logic [31:0] status_pulse;

    always #5 clk = ~clk;

    vc_frame_checker i_vc_frame_checker (
        .clk(clk), .rst(rst), .flush(flush),
        .sp_valid(sp_valid), .sp_dtype(sp_dtype), .sp_vc(sp_vc),
        .lp_done(lp_done), .lp_vc(lp_vc), .lp_crc_err(lp_crc_err),
        .status_pulse(status_pulse)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit m_open [4];
    bit m_crc  [4];

    // driver: one cycle of stimulus, expected word pushed to the scoreboard
    task automatic step(input bit r, input bit fl, input bit sv, input logic [5:0] dt,
                        input logic [1:0] sc, input bit lv, input logic [1:0] lc,
                        input bit ce, input string tag);
        logic [31:0] e;
        item_t it;
        @(negedge clk);
        rst = r; flush = fl; sp_valid = sv; sp_dtype = dt; sp_vc = sc;
        lp_done = lv; lp_vc = lc; lp_crc_err = ce;
        e = '0;
        if (r || fl) begin
            for (int c = 0; c < 4; c++) begin m_open[c] = 0; m_crc[c] = 0; end
        end else begin
            for (int c = 0; c < 4; c++) begin
                bit crc_here;
                bit fs_here;
                bit fe_here;
                crc_here = lv && ce && (lc == 2'(c));
                fs_here  = sv && dt == 6'h00 && sc == 2'(c);
                fe_here  = sv && dt == 6'h01 && sc == 2'(c);
                if (fe_here) begin
                    e[31] = 1'b1;
                    if (!m_open[c]) e[2*c+1] = 1'b1;
                    else if (m_crc[c] || crc_here) e[2*c] = 1'b1;
                    m_open[c] = 0; m_crc[c] = 0;
                end else if (fs_here) begin
                    m_open[c] = 1; m_crc[c] = crc_here;
                end else if (crc_here && m_open[c]) begin
                    m_crc[c] = 1;
                end
            end
        end
        it.exp = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 6'h00, 2'd0, 0, 2'd0, 0, tag);
    endtask

    task automatic sp(input logic [5:0] dt, input logic [1:0] v, input string tag);
        step(0, 0, 1, dt, v, 0, 2'd0, 0, tag);
    endtask

    task automatic lp(input logic [1:0] v, input bit ce, input string tag);
        step(0, 0, 0, 6'h00, 2'd0, 1, v, ce, tag);
    endtask

    // monitor: compares one queued word per cycle after the edge settles
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (status_pulse !== it.exp) begin
                errors++;
                $display("FAIL %s: status_pulse=%h expected=%h", it.tag, status_pulse, it.exp);
            end
        end
    end

    initial begin : watchdog
        #1000000;
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; flush = 0; sp_valid = 0; sp_dtype = 0; sp_vc = 0;
        lp_done = 0; lp_vc = 0; lp_crc_err = 0;
        // R1 reset state
        step(1, 0, 0, 6'h00, 2'd0, 0, 2'd0, 0, "R1");
        step(1, 0, 0, 6'h00, 2'd0, 0, 2'd0, 0, "R1");
        idle("R1");
        // R1 R2 R6: unpaired frame end on channel 2 -> bit 5
        sp(6'h01, 2'd2, "R2");
        idle("R6");
        // R4 R5: clean frames on every channel
        for (int c = 0; c < 4; c++) begin
            sp(6'h00, 2'(c), "R4");
            lp(2'(c), 0, "R4");
            sp(6'h01, 2'(c), "R5");
        end
        idle("R5");
        // R3: CRC error inside a frame on channel 1 -> bit 2 at frame end
        sp(6'h00, 2'd1, "R3");
        lp(2'd1, 1, "R3");
        idle("R3");
        sp(6'h01, 2'd1, "R3");
        idle("R3");
        // R7: other short types do not open or close frames
        sp(6'h00, 2'd0, "R7");
        sp(6'h12, 2'd0, "R7");
        sp(6'h01, 2'd0, "R7");
        sp(6'h02, 2'd3, "R7");
        sp(6'h01, 2'd3, "R7");
        // R8: restart drops the held CRC error
        sp(6'h00, 2'd3, "R8");
        lp(2'd3, 1, "R8");
        sp(6'h00, 2'd3, "R8");
        sp(6'h01, 2'd3, "R8");
        // R9: flush returns channel to idle; events under flush ignored
        sp(6'h00, 2'd2, "R9");
        step(0, 1, 1, 6'h01, 2'd0, 0, 2'd0, 0, "R9");
        idle("R9");
        sp(6'h01, 2'd2, "R9");
        // R10: interleaved channels
        sp(6'h00, 2'd0, "R10");
        sp(6'h00, 2'd1, "R10");
        step(0, 0, 1, 6'h00, 2'd2, 1, 2'd1, 1, "R10");
        step(0, 0, 1, 6'h00, 2'd3, 1, 2'd3, 1, "R10");
        step(0, 0, 1, 6'h01, 2'd0, 1, 2'd2, 0, "R10");
        sp(6'h01, 2'd1, "R10");
        sp(6'h01, 2'd2, "R10");
        sp(6'h01, 2'd3, "R10");
        // R11: CRC on idle channel ignored; same-cycle CRC with FS and FE counts
        lp(2'd0, 1, "R11");
        sp(6'h00, 2'd0, "R11");
        sp(6'h01, 2'd0, "R11");
        sp(6'h00, 2'd0, "R11");
        step(0, 0, 1, 6'h01, 2'd0, 1, 2'd0, 1, "R11");
        step(0, 0, 1, 6'h00, 2'd1, 1, 2'd1, 1, "R11");
        sp(6'h01, 2'd1, "R11");
        idle("R11");
        idle("R11");
        @(negedge clk);
        @(negedge clk);
        if (q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule